// File: doc/BRIEF.md
# Instruction Prefetch Bus Interface

This block stands between an execution core and an external memory bus that moves one byte per cycle. While the core is busy, the block fetches the next instruction bytes and keeps them in a small byte queue. The core takes bytes from the head of that queue. If the core asks for a byte while the queue is empty, it is held until a byte arrives.

The same bus also serves the core's data reads and writes. The core gives a 16-bit segment and a 16-bit offset. A dedicated adder turns the pair into a 20-bit physical address. Only this block drives the bus.

A data request never cuts into a bus cycle that has already started. Once the bus is free, a waiting data request wins over a new prefetch. A flush loads a new code segment and offset, empties the queue, and discards any fetch that is still in flight.

Top module: `fetch_bus_unit`

## Requirements
- R1: The queue holds at most DEPTH (default 4) bytes. With no byte consumed, exactly DEPTH fetch cycles start after a flush or after reset, and then the bus stays idle.
- R2: When the bus is idle, no data request is pending, a queue slot is free and no flush is present, a fetch cycle starts at the code segment and offset.
- R3: A bus cycle, once started, runs to its end with its kind unchanged (`bus_code_o` 1 = fetch, 0 = data). A data request made during a fetch starts only after that fetch ends.
- R4: When the bus is idle and a data request is pending, the next cycle to start is a data cycle, even if a queue slot is free.
- R5: Every bus cycle lasts four clocks. `bus_ale_o` is high in clock 1 with `bus_addr_o` valid. Clocks 2 and 3 are idle. In clock 4, `bus_rd_o` or `bus_wr_o` is high and `bus_rdata_i` is sampled. At least one idle clock follows before the next `bus_ale_o`.
- R6: The physical address is `(segment << 4) + offset`, taken modulo 2^20.
- R7: The code offset advances by one for each byte that is kept, and wraps from 0xFFFF to 0x0000 within the same segment.
- R8: Bytes reach the core in address order. `core_ibyte_o` is valid while `core_ibyte_vld_o` = 1, and `core_ibyte_req_i` with valid pops the byte. `core_stall_o` = 1 exactly when a byte is requested and none is valid.
- R9: `flush_i` empties the queue and loads a new code segment and offset. A fetch in flight completes on the bus, but its byte is discarded. The next byte delivered comes from the new address.
- R10: A one-clock `core_dreq_i` pulse captures segment, offset, write flag and write data. `core_ddone_o` pulses for one clock, one clock after the data cycle's clock 4, together with the read data in `core_drdata_o`. A write drives `bus_wdata_o` during the cycle.
- R11: After reset the queue is empty, no bus cycle is active, `core_ddone_o` = 0, and the first fetch goes to segment RESET_CS (default 0xFFFF), offset 0, which is physical 0xFFFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Restart prefetch at a new code address |
| flush_seg_i | input | 16 | New code segment |
| flush_off_i | input | 16 | New code offset |
| core_ibyte_req_i | input | 1 | Core wants an instruction byte |
| core_ibyte_o | output | 8 | Head byte of the queue |
| core_ibyte_vld_o | output | 1 | Head byte is valid |
| core_stall_o | output | 1 | Byte requested while the queue is empty |
| core_dreq_i | input | 1 | One-clock data access request |
| core_dwe_i | input | 1 | 1 = write, 0 = read |
| core_dseg_i | input | 16 | Data segment |
| core_doff_i | input | 16 | Data offset |
| core_dwdata_i | input | 8 | Write data |
| core_ddone_o | output | 1 | Data access complete |
| core_drdata_o | output | 8 | Read data, valid with done |
| bus_addr_o | output | 20 | Physical address of the current cycle |
| bus_ale_o | output | 1 | Address phase (clock 1) |
| bus_rd_o | output | 1 | Read strobe (clock 4) |
| bus_wr_o | output | 1 | Write strobe (clock 4) |
| bus_code_o | output | 1 | Current cycle is an instruction fetch |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, sampled in clock 4 |

## Verification
On every cycle, assertions check the following:
- the queue never overflows;
- a cycle keeps its kind until it ends;
- every address phase is followed three clocks later by the data phase;
- an idle bus with a pending data request starts a data cycle;
- the code offset steps by one per kept byte;
- the done strobe is a single pulse.

Other points only the bench scenarios can show:
- the byte order seen by the core across an offset wrap;
- the discarding of a fetch that was in flight at a flush;
- the 20-bit address wrap;
- the fill to exactly four fetches;
- read data and write data reaching the right addresses.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int unsigned SEG_W = 16;
  localparam int unsigned OFF_W = 16;
  localparam int unsigned PA_W  = 20;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } bus_st_e;
endpackage

// File: rtl/fbu_addr_gen.sv
module fbu_addr_gen #(
  parameter int unsigned SEG_W = 16,
  parameter int unsigned OFF_W = 16,
  parameter int unsigned PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  pa_o
);
  localparam int unsigned SHIFT = PA_W - SEG_W;

  logic [PA_W-1:0] seg_ext;
  logic [PA_W-1:0] off_ext;

  assign seg_ext = {seg_i, {SHIFT{1'b0}}};
  assign off_ext = {{(PA_W-OFF_W){1'b0}}, off_i};
  assign pa_o    = seg_ext + off_ext;  // carry out of PA_W dropped: wraps at top of space
endmodule

// File: rtl/fbu_byte_queue.sv
module fbu_byte_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         vld_o,
  output logic         room_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && !clr_i;
  assign do_pop  = pop_i && !clr_i && (cnt_q != '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   slot_q[g] <= '0;
      else if (do_push && wr_ptr_q == PTR_W'(g))     slot_q[g] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o = slot_q[rd_ptr_q];
  assign vld_o  = (cnt_q != '0);
  assign room_o = (cnt_q < FULL_CNT);

  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i) |-> (cnt_q < FULL_CNT || pop_i))
    else $error("R1: push into full queue");

  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT)
    else $error("R1: count above depth");
endmodule

// File: rtl/fbu_bus_seq.sv
module fbu_bus_seq
  import fbu_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pend_i,
  input  logic    room_i,
  input  logic    flush_i,
  input  logic    we_i,
  output bus_st_e st_o,
  output logic    code_o,
  output logic    start_fetch_o,
  output logic    start_data_o,
  output logic    fetch_keep_o,
  output logic    data_end_o,
  output logic    ale_o,
  output logic    rd_o,
  output logic    wr_o
);
  bus_st_e st_q, st_d;
  logic    code_q;
  logic    disc_q;
  logic    busy;

  assign busy          = (st_q != ST_IDLE);
  assign start_data_o  = (st_q == ST_IDLE) && pend_i;
  assign start_fetch_o = (st_q == ST_IDLE) && !pend_i && room_i && !flush_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_data_o || start_fetch_o) st_d = ST_T1;
      ST_T1:   st_d = ST_T2;
      ST_T2:   st_d = ST_T3;
      ST_T3:   st_d = ST_T4;
      ST_T4:   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_q <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (start_data_o || start_fetch_o) begin
        code_q <= start_fetch_o;
        disc_q <= 1'b0;
      end else if (flush_i && busy && code_q) begin
        disc_q <= 1'b1;  // byte of this fetch belongs to the old stream
      end
    end
  end

  assign st_o         = st_q;
  assign code_o       = code_q;
  assign fetch_keep_o = (st_q == ST_T4) && code_q && !disc_q && !flush_i;
  assign data_end_o   = (st_q == ST_T4) && !code_q;
  assign ale_o        = (st_q == ST_T1);
  assign rd_o         = (st_q == ST_T4) && (code_q || !we_i);
  assign wr_o         = (st_q == ST_T4) && !code_q && we_i;

  a_r3_kind_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T1 || st_q == ST_T2 || st_q == ST_T3) |=> $stable(code_q))
    else $error("R3: cycle kind changed mid-cycle");

  a_r5_four_clocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T1) |-> ##3 (st_q == ST_T4))
    else $error("R5: cycle length not four clocks");

  a_r5_idle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_T4) |=> (st_q == ST_IDLE))
    else $error("R5: no idle clock after a cycle");

  a_r4_data_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && pend_i) |=> (st_q == ST_T1 && !code_q))
    else $error("R4: pending data request not served first");
endmodule

// File: rtl/fetch_bus_unit.sv
module fetch_bus_unit
  import fbu_pkg::*;
#(
  parameter int unsigned          DEPTH    = 4,
  parameter logic [SEG_W-1:0]     RESET_CS = 16'hFFFF,
  parameter logic [OFF_W-1:0]     RESET_IP = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [SEG_W-1:0]  flush_seg_i,
  input  logic [OFF_W-1:0]  flush_off_i,
  input  logic              core_ibyte_req_i,
  output logic [BYTE_W-1:0] core_ibyte_o,
  output logic              core_ibyte_vld_o,
  output logic              core_stall_o,
  input  logic              core_dreq_i,
  input  logic              core_dwe_i,
  input  logic [SEG_W-1:0]  core_dseg_i,
  input  logic [OFF_W-1:0]  core_doff_i,
  input  logic [BYTE_W-1:0] core_dwdata_i,
  output logic              core_ddone_o,
  output logic [BYTE_W-1:0] core_drdata_o,
  output logic [PA_W-1:0]   bus_addr_o,
  output logic              bus_ale_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic              bus_code_o,
  output logic [BYTE_W-1:0] bus_wdata_o,
  input  logic [BYTE_W-1:0] bus_rdata_i
);
  logic [SEG_W-1:0]  cs_q, dseg_q;
  logic [OFF_W-1:0]  ip_q, doff_q;
  logic              dwe_q, pend_q;
  logic [BYTE_W-1:0] dwd_q, drd_q;
  logic              ddone_q;
  logic [PA_W-1:0]   addr_q, pa;
  logic [SEG_W-1:0]  seg_sel;
  logic [OFF_W-1:0]  off_sel;

  bus_st_e st;
  logic    code, start_fetch, start_data, fetch_keep, data_end;
  logic    q_vld, q_room, q_pop;

  fbu_bus_seq i_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pend_i        (pend_q),
    .room_i        (q_room),
    .flush_i       (flush_i),
    .we_i          (dwe_q),
    .st_o          (st),
    .code_o        (code),
    .start_fetch_o (start_fetch),
    .start_data_o  (start_data),
    .fetch_keep_o  (fetch_keep),
    .data_end_o    (data_end),
    .ale_o         (bus_ale_o),
    .rd_o          (bus_rd_o),
    .wr_o          (bus_wr_o)
  );

  // one adder shared by code and data addressing
  assign seg_sel = start_data ? dseg_q : cs_q;
  assign off_sel = start_data ? doff_q : ip_q;

  fbu_addr_gen #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_agen (
    .seg_i (seg_sel),
    .off_i (off_sel),
    .pa_o  (pa)
  );

  assign q_pop = core_ibyte_req_i && q_vld;

  fbu_byte_queue #(.DEPTH(DEPTH), .W(BYTE_W)) i_queue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flush_i),
    .push_i (fetch_keep),
    .din_i  (bus_rdata_i),
    .pop_i  (q_pop),
    .dout_o (core_ibyte_o),
    .vld_o  (q_vld),
    .room_o (q_room)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= RESET_CS;
      ip_q <= RESET_IP;
    end else if (flush_i) begin
      cs_q <= flush_seg_i;
      ip_q <= flush_off_i;
    end else if (fetch_keep) begin
      ip_q <= ip_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dseg_q <= '0;
      doff_q <= '0;
      dwe_q  <= 1'b0;
      dwd_q  <= '0;
    end else begin
      if (core_dreq_i) begin
        pend_q <= 1'b1;
        dseg_q <= core_dseg_i;
        doff_q <= core_doff_i;
        dwe_q  <= core_dwe_i;
        dwd_q  <= core_dwdata_i;
      end else if (start_data) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      ddone_q <= 1'b0;
      drd_q   <= '0;
    end else begin
      if (start_data || start_fetch) addr_q <= pa;
      ddone_q <= data_end;
      if (data_end && !dwe_q) drd_q <= bus_rdata_i;
    end
  end

  assign core_ibyte_vld_o = q_vld;
  assign core_stall_o     = core_ibyte_req_i && !q_vld;
  assign core_ddone_o     = ddone_q;
  assign core_drdata_o    = drd_q;
  assign bus_addr_o       = addr_q;
  assign bus_code_o       = code && (st != ST_IDLE);
  assign bus_wdata_o      = dwd_q;

  a_r7_ip_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_keep && !flush_i) |=> (ip_q == $past(ip_q) + 16'd1))
    else $error("R7: code offset did not advance by one");

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ddone_o |=> !core_ddone_o)
    else $error("R10: done longer than one clock");

  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_T2 || st == ST_T3 || st == ST_T4) |-> $stable(bus_addr_o))
    else $error("R5: address moved inside a cycle");
endmodule

// File: tb/test_fetch_bus_unit.sv
module test_fetch_bus_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] flush_seg = '0, flush_off = '0;
  logic        ireq = 1'b0;
  logic [7:0]  ibyte;
  logic        ivld, stall;
  logic        dreq = 1'b0, dwe = 1'b0;
  logic [15:0] dseg = '0, doff = '0;
  logic [7:0]  dwd = '0;
  logic        ddone;
  logic [7:0]  drd;
  logic [19:0] baddr;
  logic        ale, brd, bwr, bcode;
  logic [7:0]  bwd, brdata;

  int checks = 0, fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_f(input logic [19:0] a);
    return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A ^ {a[15:12], 4'h3};
  endfunction
  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  assign brdata = mem_f(baddr);

  fetch_bus_unit i_fetch_bus_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .flush_i(flush), .flush_seg_i(flush_seg), .flush_off_i(flush_off),
    .core_ibyte_req_i(ireq), .core_ibyte_o(ibyte), .core_ibyte_vld_o(ivld), .core_stall_o(stall),
    .core_dreq_i(dreq), .core_dwe_i(dwe), .core_dseg_i(dseg), .core_doff_i(doff),
    .core_dwdata_i(dwd), .core_ddone_o(ddone), .core_drdata_o(drd),
    .bus_addr_o(baddr), .bus_ale_o(ale), .bus_rd_o(brd), .bus_wr_o(bwr),
    .bus_code_o(bcode), .bus_wdata_o(bwd), .bus_rdata_i(brdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  typedef struct { logic [19:0] a; bit we; logic [7:0] wd; } dacc_t;
  logic [7:0] exp_bytes[$];
  dacc_t      exp_data[$];
  dacc_t      cur_d;
  int  last_ale = -100, last_data_ale = -100;
  bit  ale_code, want_data_next = 1'b0, first_fetch = 1'b1;
  int  fetch_ales = 0, done_cnt = 0;

  // scoreboard driver side
  task automatic push_stream(input logic [15:0] s, input logic [15:0] o, input int n);
    for (int k = 0; k < n; k++) exp_bytes.push_back(mem_f(phys(s, o + 16'(k))));
  endtask

  // monitor: samples at falling edge, inputs change at rising edge + 2
  always @(negedge clk) if (rst_n) begin
    if (ale) begin
      chk(cyc - last_ale >= 5, "R5 ale spacing", cyc - last_ale, 5);
      last_ale = cyc;
      ale_code = bcode;
      if (bcode) begin
        fetch_ales++;
        if (first_fetch) begin
          chk(baddr == 20'hFFFF0, "R11 first fetch address", baddr, 20'hFFFF0);
          first_fetch = 1'b0;
        end
      end
      if (want_data_next) begin
        chk(!bcode, "R4 data cycle first", bcode, 0);
        want_data_next = 1'b0;
      end
      if (!bcode) begin
        last_data_ale = cyc;
        if (exp_data.size() == 0) chk(1'b0, "R10 unexpected data cycle", baddr, 0);
        else begin
          cur_d = exp_data.pop_front();
          chk(baddr == cur_d.a, "R6 data address", baddr, cur_d.a);
        end
      end
    end
    if (brd || bwr) begin
      chk(cyc - last_ale == 3, "R5 data phase in clock 4", cyc - last_ale, 3);
      chk(bcode == ale_code, "R3 cycle kind held", bcode, ale_code);
      if (bwr) chk(bwd == cur_d.wd, "R10 write data", bwd, cur_d.wd);
    end
    if (ddone) begin
      done_cnt++;
      chk(cyc - last_data_ale == 4, "R10 done timing", cyc - last_data_ale, 4);
      if (!cur_d.we) chk(drd == mem_f(cur_d.a), "R10 read data", drd, mem_f(cur_d.a));
    end
    if (ireq && ivld) begin
      if (exp_bytes.size() == 0) chk(1'b0, "R8 unexpected byte", ibyte, 0);
      else begin
        logic [7:0] e;
        e = exp_bytes.pop_front();
        chk(ibyte == e, "R8 byte order", ibyte, e);
      end
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
    flush = 1'b1; flush_seg = s; flush_off = o;
    step();
    flush = 1'b0;
  endtask

  task automatic drain();
    ireq = 1'b1;
    wait (exp_bytes.size() == 0);
    step();
    ireq = 1'b0;
  endtask

  task automatic wait_fetch_ale();
    do @(negedge clk); while (!(ale && bcode));
    step();
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!ivld, "R11 queue empty", ivld, 0);
    chk(!ale && !brd && !bwr, "R11 bus idle", {ale, brd, bwr}, 0);
    chk(!ddone, "R11 no done", ddone, 0);
    step(); rst_n = 1'b1;

    // R1/R2: fill without consuming
    repeat (40) step();
    chk(fetch_ales == 4, "R1 fetches to fill", fetch_ales, 4);
    chk(ivld, "R2 prefetched byte valid", ivld, 1);

    // R8 order from reset address
    push_stream(16'hFFFF, 16'h0000, 8);
    drain();

    // R1 after flush, queue full again, bus idle
    repeat (40) step();
    fetch_ales = 0;
    do_flush(16'h1234, 16'hFFFE);
    repeat (40) step();
    chk(fetch_ales == 4, "R1 fetches after flush", fetch_ales, 4);

    // R7 wrap, R9 flush, R8 stall
    do_flush(16'h1234, 16'hFFFE);
    push_stream(16'h1234, 16'hFFFE, 6);
    ireq = 1'b1;
    @(negedge clk);
    chk(stall, "R8 stall on empty queue", stall, 1);
    chk(!ivld, "R9 queue emptied by flush", ivld, 0);
    drain();
    @(negedge clk);
    chk(!stall, "R8 no stall without request", stall, 0);

    // R3 data request during fetch; R6 wrap to 0xFFFFF
    step();
    do_flush(16'h2000, 16'h0000);
    wait_fetch_ale();
    exp_data.push_back('{a: phys(16'hF000, 16'hFFFF), we: 1'b0, wd: 8'h00});
    dreq = 1'b1; dwe = 1'b0; dseg = 16'hF000; doff = 16'hFFFF;
    want_data_next = 1'b1;
    step(); dreq = 1'b0;
    wait (done_cnt == 1);
    chk(phys(16'hF000, 16'hFFFF) == 20'hFFFFF, "R6 bench address model", 0, 0);

    // R4 priority over free queue slots; R6 20-bit wrap; R10 write
    repeat (40) step();
    exp_data.push_back('{a: 20'h0FFEF, we: 1'b1, wd: 8'hA5});
    dreq = 1'b1; dwe = 1'b1; dseg = 16'hFFFF; doff = 16'hFFFF; dwd = 8'hA5;
    flush = 1'b1; flush_seg = 16'h5000; flush_off = 16'h0000;
    want_data_next = 1'b1;
    step(); dreq = 1'b0; flush = 1'b0;
    wait (done_cnt == 2);
    step();
    push_stream(16'h5000, 16'h0000, 4);
    drain();

    // R9 flush while a fetch is in flight
    do_flush(16'h3000, 16'h0010);
    wait_fetch_ale();
    do_flush(16'h4000, 16'h0020);
    push_stream(16'h4000, 16'h0020, 6);
    drain();

    repeat (10) step();
    chk(exp_data.size() == 0, "R10 all data cycles seen", exp_data.size(), 0);
    chk(exp_bytes.size() == 0, "R8 all bytes delivered", exp_bytes.size(), 0);
    finish_up();
  end
endmodule